// File: doc/BRIEF.md
# Parallel Configuration Host Sequencer

This block is the host side of a byte-wide configuration port that loads a chain of configurable devices. Every device in the chain shares one restart line, one open-drain status line, one done line, the configuration clock and the 8-bit data bus. The host therefore sends a single unbroken bitstream and never picks a device. The passing of the load from one device to the next happens inside the chain and the host does not see it.

A `start` pulse begins an attempt. The sequencer holds the restart line low for a set number of cycles and releases it. It then waits, with a time limit, for the status line to be released. Next it moves bytes from a valid/ready byte source onto the data bus and gives each byte one rising configuration-clock edge. After the byte flagged last it sends a set number of extra clock edges and waits for the done line. A low status line during loading, a status time-out, or a missing done edge ends the attempt. The sequencer then rewinds the source and restarts the whole chain until the retry budget is used up.

Back-pressure rules: a byte moves on a clock edge where both `src_valid` and `src_ready` are high. `src_ready` is high only while loading, and never while a byte already on the bus is still waiting for its rising clock edge. The source may hold `src_valid` low for any number of cycles. The configuration clock then stays low and the bus holds the last byte. The source must drive `src_last` high with its final byte. It must return to the first byte after a cycle with `src_rewind` high.

Top module: `pcfg_host_seq`

## Requirements
- R1: After reset the restart line is high, the configuration clock is low, the data bus is zero, `src_ready`, `src_rewind`, `busy`, `done` and `error` are low, and `retry_cnt` is zero.
- R2: A `start` pulse while not busy drives the restart line low for exactly RST_CYCLES clock cycles and then releases it. A `start` pulse while busy has no effect on the attempt in progress.
- R3: After the restart line is released, loading begins once the status line reads high. If it stays low for STATUS_TIMEOUT cycles, the attempt fails.
- R4: Each accepted byte appears on the data bus with the configuration clock low, and is held unchanged across the next rising clock edge. Bytes reach the bus in acceptance order, one rising edge per byte, with no edges added between bytes.
- R5: While `src_valid` is low during loading, the configuration clock produces no rising edge beyond the one owed to the byte already accepted.
- R6: After the last byte the sequencer gives at most INIT_CLOCKS extra rising edges. A high done line within them ends the run with `done` high, `busy` low and the clock parked low.
- R7: If the done line is still low after INIT_CLOCKS extra rising edges, the attempt fails.
- R8: A low status line at any time during loading or the extra edges fails the attempt at once.
- R9: A failed attempt with `retry_cnt` below MAX_RETRY raises `retry_cnt` by one and pulses `src_rewind` for one cycle while the restart line goes low. The next attempt then sends the stream again from its first byte.
- R10: A failed attempt with `retry_cnt` equal to MAX_RETRY leaves `error` high, `busy` low and the restart line high. A later `start` begins a new run with `retry_cnt` cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a configuration run |
| src_valid | input | 1 | Byte source has a byte on `src_data` |
| src_ready | output | 1 | Sequencer accepts the presented byte this cycle |
| src_data | input | 8 | Bitstream byte from the source |
| src_last | input | 1 | Presented byte is the final one of the bitstream |
| src_rewind | output | 1 | One-cycle request for the source to restart from its first byte |
| cfg_restart_n | output | 1 | Shared active-low chain restart line |
| cfg_status_n | input | 1 | Shared wired-AND status line, low means reset or error |
| cfg_done | input | 1 | Shared wired-AND done line, high when every device is loaded |
| cfg_dclk | output | 1 | Configuration clock to the chain |
| cfg_data | output | 8 | Configuration data bus to the chain |
| busy | output | 1 | An attempt is under way |
| done | output | 1 | Last run completed successfully |
| error | output | 1 | Last run failed after all retries |
| retry_cnt | output | RW | Number of retries used in the current or last run |

## Verification
The checker assumes that `cfg_status_n` and `cfg_done` change in step with `clk`, that `start` is a single-cycle pulse, and that `src_last` marks exactly one byte per pass. The bench's chain model drives the status and done lines only at falling system-clock edges from one process. It pulls status low whenever the restart line is low and drops done at every restart, which matches how a real chain reacts. The byte source holds the stream in a table, flags the final byte and returns to the table start on every rewind pulse. Its random valid gaps and its long directed gap therefore stay within the handshake rules above.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PULSE  = 3'd1,
    S_WAITST = 3'd2,
    S_STREAM = 3'd3,
    S_POST   = 3'd4,
    S_DONE   = 3'd5,
    S_FAIL   = 3'd6
  } pcfg_state_e;

endpackage

// File: rtl/pcfg_timer.sv
// Loadable down counter shared by the restart, status-wait and
// extra-clock phases.
module pcfg_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          is_zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/pcfg_retry.sv
// Counts retries inside one run and flags when the budget is spent.
module pcfg_retry #(
  parameter int MAX_RETRY = 2,
  parameter int RW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [RW-1:0] count,
  output logic          spent
);

  localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;
  assign spent = (cnt_q == LIMIT);

endmodule

// File: rtl/pcfg_lane.sv
// Byte lane: owns the configuration clock and data bus. A byte is
// loaded with the clock low, the clock then rises one cycle later and
// falls again on the edge where the next byte may be loaded.
module pcfg_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en_stream,
  input  logic          en_post,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          dclk,
  output logic [DW-1:0] bus,
  output logic          stream_end,
  output logic          dclk_high
);

  logic          dclk_q;
  logic          pend_q;
  logic          last_q;
  logic [DW-1:0] bus_q;
  logic          take;

  // Ready while the clock is high (it falls now) or nothing is pending.
  assign in_ready   = en_stream && !last_q && (dclk_q || !pend_q);
  assign take       = in_valid && in_ready;
  assign stream_end = en_stream && last_q && pend_q && dclk_q;
  assign dclk_high  = dclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      dclk_q <= 1'b0;
      pend_q <= 1'b0;
      last_q <= 1'b0;
      bus_q  <= '0;
    end else if (en_stream) begin
      if (take) begin
        bus_q  <= in_data;
        pend_q <= 1'b1;
        last_q <= in_last;
        dclk_q <= 1'b0;
      end else if (dclk_q) begin
        dclk_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (pend_q) begin
        dclk_q <= 1'b1;
      end
    end else if (en_post) begin
      dclk_q <= ~dclk_q;
    end
  end

  assign dclk = dclk_q;
  assign bus  = bus_q;

endmodule

// File: rtl/pcfg_host_seq.sv
module pcfg_host_seq
  import pcfg_pkg::*;
#(
  parameter int RST_CYCLES     = 4,
  parameter int STATUS_TIMEOUT = 16,
  parameter int INIT_CLOCKS    = 8,
  parameter int MAX_RETRY      = 2,
  parameter int CW             = 8,
  parameter int RW             = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [7:0]    src_data,
  input  logic          src_last,
  output logic          src_rewind,
  output logic          cfg_restart_n,
  input  logic          cfg_status_n,
  input  logic          cfg_done,
  output logic          cfg_dclk,
  output logic [7:0]    cfg_data,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [RW-1:0] retry_cnt
);

  localparam logic [CW-1:0] RST_LD  = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] TO_LD   = CW'(STATUS_TIMEOUT - 1);
  localparam logic [CW-1:0] INIT_LD = CW'(INIT_CLOCKS - 1);

  pcfg_state_e   state_q, state_d;
  logic          tmr_load, tmr_dec, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          rty_clr, rty_inc, rty_spent;
  logic          bad;
  logic          rewind_q, rewind_d;
  logic          lane_clr, lane_end, lane_high;

  pcfg_timer #(.CW(CW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .is_zero  (tmr_zero)
  );

  pcfg_retry #(.MAX_RETRY(MAX_RETRY), .RW(RW)) rty_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rty_clr),
    .inc   (rty_inc),
    .count (retry_cnt),
    .spent (rty_spent)
  );

  pcfg_lane #(.DW(8)) lane_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (lane_clr),
    .en_stream  (state_q == S_STREAM),
    .en_post    (state_q == S_POST),
    .in_valid   (src_valid),
    .in_data    (src_data),
    .in_last    (src_last),
    .in_ready   (src_ready),
    .dclk       (cfg_dclk),
    .bus        (cfg_data),
    .stream_end (lane_end),
    .dclk_high  (lane_high)
  );

  // Attempt-failure detection per phase.
  always_comb begin
    bad = 1'b0;
    unique case (state_q)
      S_WAITST: bad = !cfg_status_n && tmr_zero;
      S_STREAM: bad = !cfg_status_n;
      S_POST:   bad = !cfg_status_n || (!cfg_done && lane_high && tmr_zero);
      default:  bad = 1'b0;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = RST_LD;
    tmr_dec  = 1'b0;
    rty_clr  = 1'b0;
    rty_inc  = 1'b0;
    rewind_d = 1'b0;
    if (bad) begin
      if (rty_spent) begin
        state_d = S_FAIL;
      end else begin
        state_d  = S_PULSE;
        tmr_load = 1'b1;
        tmr_val  = RST_LD;
        rty_inc  = 1'b1;
        rewind_d = 1'b1;
      end
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE, S_FAIL: begin
          if (start) begin
            state_d  = S_PULSE;
            tmr_load = 1'b1;
            tmr_val  = RST_LD;
            rty_clr  = 1'b1;
          end
        end
        S_PULSE: begin
          if (tmr_zero) begin
            state_d  = S_WAITST;
            tmr_load = 1'b1;
            tmr_val  = TO_LD;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        S_WAITST: begin
          if (cfg_status_n) state_d = S_STREAM;
          else              tmr_dec = 1'b1;
        end
        S_STREAM: begin
          if (lane_end) begin
            state_d  = S_POST;
            tmr_load = 1'b1;
            tmr_val  = INIT_LD;
          end
        end
        S_POST: begin
          if (cfg_done)       state_d = S_DONE;
          else if (lane_high) tmr_dec = 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  // Park the lane whenever the next state is not a clocking phase.
  assign lane_clr = !((state_d == S_STREAM) || (state_d == S_POST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      rewind_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rewind_q <= rewind_d;
    end
  end

  assign src_rewind    = rewind_q;
  assign cfg_restart_n = (state_q != S_PULSE);
  assign done          = (state_q == S_DONE);
  assign error         = (state_q == S_FAIL);
  assign busy          = !((state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_FAIL));

endmodule

// File: rtl/pcfg_host_seq_chk.sv
module pcfg_host_seq_chk #(
  parameter int RST_CYCLES = 4,
  parameter int MAX_RETRY  = 2,
  parameter int RW         = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_ready,
  input logic          src_rewind,
  input logic          cfg_restart_n,
  input logic          cfg_done,
  input logic          cfg_dclk,
  input logic [7:0]    cfg_data,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic [RW-1:0] retry_cnt
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)             low_run <= '0;
    else if (cfg_restart_n) low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
  end

  a_r2_restart_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_restart_n) |-> (low_run == 16'(RST_CYCLES)));

  a_r4_data_held_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_dclk) |-> $stable(cfg_data));

  a_r4_ready_only_loading: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (busy && cfg_restart_n));

  a_r6_clock_parked_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !cfg_restart_n) |-> !cfg_dclk);

  a_r6_done_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cfg_done));

  a_r9_rewind_with_restart: assert property (@(posedge clk) disable iff (!rst_n)
    src_rewind |-> (!cfg_restart_n && (retry_cnt != '0)));

  a_r10_retry_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RW'(MAX_RETRY));

  a_r10_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (cfg_restart_n && !src_ready && !busy && !done && (retry_cnt == RW'(MAX_RETRY))));

endmodule

bind pcfg_host_seq pcfg_host_seq_chk #(
  .RST_CYCLES (RST_CYCLES),
  .MAX_RETRY  (MAX_RETRY),
  .RW         (RW)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_ready     (src_ready),
  .src_rewind    (src_rewind),
  .cfg_restart_n (cfg_restart_n),
  .cfg_done      (cfg_done),
  .cfg_dclk      (cfg_dclk),
  .cfg_data      (cfg_data),
  .busy          (busy),
  .done          (done),
  .error         (error),
  .retry_cnt     (retry_cnt)
);

// File: tb/pcfg_host_seq_tb_top.sv
module pcfg_host_seq_tb_top;

  localparam int RST_CYCLES     = 4;
  localparam int STATUS_TIMEOUT = 10;
  localparam int INIT_CLOCKS    = 6;
  localparam int MAX_RETRY      = 2;
  localparam int RW             = $clog2(MAX_RETRY + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [7:0]    src_data = '0;
  logic          src_last = 1'b0;
  logic          src_rewind;
  logic          cfg_restart_n;
  logic          cfg_status_n = 1'b0;
  logic          cfg_done = 1'b0;
  logic          cfg_dclk;
  logic [7:0]    cfg_data;
  logic          busy, done, error;
  logic [RW-1:0] retry_cnt;

  pcfg_host_seq #(
    .RST_CYCLES(RST_CYCLES), .STATUS_TIMEOUT(STATUS_TIMEOUT),
    .INIT_CLOCKS(INIT_CLOCKS), .MAX_RETRY(MAX_RETRY), .CW(8), .RW(RW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .src_last(src_last), .src_rewind(src_rewind),
    .cfg_restart_n(cfg_restart_n), .cfg_status_n(cfg_status_n),
    .cfg_done(cfg_done), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data),
    .busy(busy), .done(done), .error(error), .retry_cnt(retry_cnt)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Source and chain model state
  logic [7:0] mem [0:63];
  int  len = 0, idx = 0, gap_pct = 0, gap_at = -1, gap_left = 0, gap_cnt = 0, gap_rises = 0;
  bit  pend = 0;
  bit  st_en = 1, done_en = 1, flt = 0, prev_rn = 1, prev_dclk = 0;
  int  st_delay = 3, done_after = 2, fault_att = -1, fault_edge = 0;
  int  attempt = -1, edges = 0, since_rel = 0, rewinds = 0;
  int  low_run = 0, last_low = 0, hi_run = 0, last_hi = 0;
  int  att_edges [0:31];
  logic [7:0] cap [0:63];
  int  ncap = 0;
  bit  model_on = 0;

  task automatic model_step();
    // monitor
    if (prev_rn && !cfg_restart_n) begin
      attempt++;
      if (attempt < 32) att_edges[attempt] = 0;
      last_hi = hi_run; hi_run = 0; edges = 0; ncap = 0; flt = 0;
    end
    if (!prev_rn && cfg_restart_n) begin last_low = low_run; low_run = 0; end
    if (!cfg_restart_n) low_run++; else hi_run++;
    if (cfg_dclk && !prev_dclk) begin
      edges++;
      if (attempt >= 0 && attempt < 32) att_edges[attempt]++;
      if (ncap < 64) begin cap[ncap] = cfg_data; ncap++; end
      if (gap_left > 0 && gap_cnt >= 3) gap_rises++;
    end
    prev_rn = cfg_restart_n; prev_dclk = cfg_dclk;
    // source bookkeeping: handshake at the edge just passed
    if (pend) idx++;
    pend = 0;
    if (src_rewind) begin rewinds++; idx = 0; end
    // chain model
    if (!cfg_restart_n) begin
      cfg_status_n = 1'b0; cfg_done = 1'b0; since_rel = 0;
    end else begin
      since_rel++;
      if (attempt == fault_att && edges >= fault_edge) flt = 1;
      cfg_status_n = st_en && (since_rel >= st_delay) && !flt;
      cfg_done = done_en && (edges >= len + done_after);
    end
    // source drive
    if (gap_at >= 0 && idx == gap_at && gap_left > 0) begin
      src_valid = 1'b0; gap_left--; gap_cnt++;
    end else if (idx < len) begin
      src_valid = ($urandom_range(99) >= gap_pct);
    end else begin
      src_valid = 1'b0;
    end
    src_data = (idx < len) ? mem[idx] : 8'h00;
    src_last = (idx == len - 1);
    pend = src_valid && src_ready;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (model_on) model_step();
    end
  end

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_end(input int limit);
    int k;
    k = 0;
    @(negedge clk);
    while (busy && k < limit) begin @(negedge clk); k++; end
    #2;
  endtask

  task automatic fill(input int n);
    len = n; idx = 0;
    for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
  endtask

  function automatic int count_byte_mismatch(input int n);
    int m;
    m = 0;
    for (int i = 0; i < n; i++) if (cap[i] !== mem[i]) m++;
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base_att, base_rw;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(cfg_restart_n == 1'b1, "R1 restart_n", cfg_restart_n, 1);
    chk(cfg_dclk == 1'b0, "R1 dclk", cfg_dclk, 0);
    chk(cfg_data == 8'h00, "R1 data", cfg_data, 0);
    chk({src_ready, src_rewind, busy, done, error} == 5'b0, "R1 flags",
        {src_ready, src_rewind, busy, done, error}, 0);
    chk(retry_cnt == '0, "R1 retry_cnt", retry_cnt, 0);
    model_on = 1;

    // Directed clean run: R2, R4, R6
    fill(6); gap_pct = 0; st_en = 1; done_en = 1; fault_att = -1;
    base_rw = rewinds;
    pulse_start();
    wait_end(2000);
    chk(done == 1'b1 && error == 1'b0, "R6 done flag", done, 1);
    chk(busy == 1'b0 && cfg_dclk == 1'b0, "R6 parked", {busy, cfg_dclk}, 0);
    chk(last_low == RST_CYCLES, "R2 restart width", last_low, RST_CYCLES);
    chk(count_byte_mismatch(6) == 0, "R4 bytes clean", count_byte_mismatch(6), 0);
    chk(att_edges[attempt] == 6 + done_after, "R6 edge count", att_edges[attempt], 6 + done_after);
    chk(retry_cnt == '0 && rewinds == base_rw, "R9 no retry", retry_cnt, 0);

    // Random gaps plus long directed gap and start while busy: R2, R4, R5
    fill(40); gap_pct = 40; gap_at = 5; gap_left = 12; gap_cnt = 0; gap_rises = 0;
    base_att = attempt;
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_end(5000);
    chk(attempt == base_att + 1, "R2 start ignored while busy", attempt - base_att, 1);
    chk(done == 1'b1, "R6 done random", done, 1);
    chk(count_byte_mismatch(40) == 0, "R4 bytes random", count_byte_mismatch(40), 0);
    chk(att_edges[attempt] == 40 + done_after, "R4 one edge per byte", att_edges[attempt], 40 + done_after);
    chk(gap_rises == 0, "R5 quiet clock in gap", gap_rises, 0);
    gap_at = -1;

    // Done never rises: R7, R9, R10
    fill(5); gap_pct = 20; done_en = 0;
    base_att = attempt; base_rw = rewinds;
    pulse_start();
    wait_end(5000);
    chk(error == 1'b1 && done == 1'b0, "R7 error flag", error, 1);
    chk(rewinds - base_rw == MAX_RETRY, "R9 rewinds", rewinds - base_rw, MAX_RETRY);
    chk(retry_cnt == RW'(MAX_RETRY), "R10 retry_cnt", retry_cnt, MAX_RETRY);
    for (int a = base_att + 1; a <= attempt; a++)
      chk(att_edges[a] == 5 + INIT_CLOCKS, "R7 extra edges", att_edges[a], 5 + INIT_CLOCKS);
    chk(cfg_restart_n == 1'b1 && busy == 1'b0, "R10 idle after fail", {cfg_restart_n, busy}, 2);

    // Status never released: R3
    done_en = 1; st_en = 0;
    base_att = attempt;
    pulse_start();
    wait_end(5000);
    chk(attempt - base_att == MAX_RETRY + 1, "R3 attempts", attempt - base_att, MAX_RETRY + 1);
    chk(last_hi == STATUS_TIMEOUT, "R3 timeout width", last_hi, STATUS_TIMEOUT);
    chk(error == 1'b1, "R3 error", error, 1);

    // Status drop mid-stream on first attempt, then success: R8, R9, R10
    fill(12); gap_pct = 25; st_en = 1;
    fault_att = attempt + 1; fault_edge = 3;
    base_rw = rewinds;
    pulse_start();
    @(negedge clk); #1;
    chk(retry_cnt == '0, "R10 retry cleared on start", retry_cnt, 0);
    wait_end(5000);
    chk(done == 1'b1, "R8 recovered done", done, 1);
    chk(retry_cnt == RW'(1), "R9 one retry", retry_cnt, 1);
    chk(rewinds - base_rw == 1, "R9 one rewind", rewinds - base_rw, 1);
    chk(count_byte_mismatch(12) == 0, "R8 full restream", count_byte_mismatch(12), 0);
    chk(att_edges[fault_att] < 12, "R8 abort early", att_edges[fault_att], 3);
    fault_att = -1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule